// File: doc/BRIEF.md
# Multi-Slot Conversion Sequencer

This block decides, for an analog-to-digital converter, which of sixteen conversion-control slots is used for each conversion and where each result lands. Every slot holds a channel number, a reference select and an end-of-sequence bit. A hidden pointer starts at a programmable slot. It advances after each conversion and wraps from the last slot back to slot 0. In the sequence modes it stops after converting a slot whose end bit is set.

The sequencer drives a separate timing controller through a one-cycle start pulse, which carries the channel and reference of the current slot. It waits for a done pulse that carries the result. Results go into a per-slot store with an unread flag and a shared overflow flag. Reading a slot returns its result and clears its flag. An enable mask turns the flags into a single interrupt request.

Four modes are selected by a 2-bit field: 0 single slot once, 1 sequence once, 2 repeat single slot, 3 repeat sequence. A back-to-back option lets one trigger run a whole sequence, or run the repeat-single mode continuously. Triggers come either from a software start pulse or from the rising edge of a hardware trigger input. Clearing enable stops the block according to the mode in use.

Top module: `adc_seq_ctrl`

## Requirements
- R1: With mode 0 and enable high, an accepted trigger runs exactly one conversion of the slot at start_addr, stores the result in that slot, and returns busy to 0.
- R2: With mode 1, conversions use slots start_addr, start_addr+1, … and wrap from slot 15 to slot 0. The run ends after the first slot whose end bit is set. Each result is stored in the slot that was converted.
- R3: With multi low in modes 1, 2 and 3, each conversion of a run needs its own trigger. Between triggers, busy stays high and no conversion starts.
- R4: With multi high and mode above 0, one trigger starts the run and each following conversion starts on the cycle after the previous done. Triggers that arrive during the run are ignored.
- R5: Mode 2 converts the slot at start_addr again and again. After enable is cleared, the conversion in flight completes and is stored, and no further conversion starts.
- R6: Mode 3 returns to idle after a slot with its end bit set. The next trigger restarts the run at start_addr.
- R7: If enable is cleared during a mode 1 or mode 3 run, the remaining slots up to the end bit are converted back-to-back without triggers, and then the block idles.
- R8: With trig_sw_sel=0 (trigger = rising edge of hw_trig), a completed mode 0 or mode 1 run blocks further triggers until enable has been low. With trig_sw_sel=1 (trigger = sw_start pulse), repeated starts are accepted.
- R9: Storing a result sets flags[slot]. Asserting rd_en shows that slot's result on rd_data, and at the clock edge it clears flags[rd_addr].
- R10: ovf is set when a result is stored into a slot whose flag is still set (and is not being read in the same cycle). ovf stays set until ovf_clr.
- R11: irq is high exactly when some bit of flags AND ie_mask is set.
- R12: Enable low while mode is 0 (or while a mode 0 run is active) returns busy to 0 at the next clock edge, and a done arriving after that stores nothing.
- R13: After reset busy, conv_start, flags, ovf and irq are 0. conv_start is a one-cycle pulse, and while it is high conv_chan and conv_ref carry the converted slot's fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Conversion enable |
| mode | input | 2 | 0 single, 1 sequence, 2 repeat single, 3 repeat sequence |
| start_addr | input | 4 | First (or only) slot of a run |
| multi | input | 1 | Back-to-back conversion option |
| trig_sw_sel | input | 1 | 1: sw_start is the trigger; 0: rising edge of hw_trig |
| sw_start | input | 1 | Software start pulse |
| hw_trig | input | 1 | Hardware trigger level |
| slot_we | input | 1 | Slot write strobe |
| slot_waddr | input | 4 | Slot to write |
| slot_wchan | input | 4 | Channel number written |
| slot_wref | input | 3 | Reference select written |
| slot_weos | input | 1 | End-of-sequence bit written |
| conv_start | output | 1 | Start pulse to the timing controller |
| conv_chan | output | 4 | Channel of the slot being converted |
| conv_ref | output | 3 | Reference of the slot being converted |
| conv_done | input | 1 | Conversion complete pulse |
| conv_data | input | 12 | Conversion result, valid with conv_done |
| rd_en | input | 1 | Result read strobe |
| rd_addr | input | 4 | Slot to read |
| rd_data | output | 12 | Stored result of rd_addr |
| ie_mask | input | 16 | Per-slot interrupt enables |
| ovf_clr | input | 1 | Clears ovf |
| flags | output | 16 | Per-slot unread result flags |
| ovf | output | 1 | Overflow flag |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | A run is in progress |

## Verification
A trigger seen at one rising edge produces conv_start during the following cycle. A done seen at an edge makes its flag, ovf and irq visible right after that edge. In back-to-back runs, the next conv_start follows the done edge by one cycle, and an abort or read clear acts at the next edge. The bench drives inputs at the falling edge and samples one time step after a falling edge, so each result is taken in the first half-cycle where it is due. Its converter model answers every start three cycles later, encodes the channel in the result, and logs the channel and reference. Order, wrap and restart points are therefore checked against the log.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int CHAN_W = 4;
    localparam int REF_W  = 3;

    typedef enum logic [1:0] {
        MODE_SINGLE     = 2'd0,
        MODE_SEQ        = 2'd1,
        MODE_REP_SINGLE = 2'd2,
        MODE_REP_SEQ    = 2'd3
    } seq_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_CONV = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [REF_W-1:0]  refsel;
        logic              eos;
    } slot_t;
endpackage

// File: rtl/adc_seq_slot_bank.sv
module adc_seq_slot_bank
    import adc_seq_pkg::*;
#(
    parameter int N_SLOTS = 16,
    localparam int ADDR_W = $clog2(N_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  slot_t             wslot,
    input  logic [ADDR_W-1:0] raddr,
    output slot_t             rslot
);
    slot_t [N_SLOTS-1:0] slots_d, slots_q;

    always_comb begin
        slots_d = slots_q;
        if (we) slots_d[waddr] = wslot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slots_q <= '0;
        else        slots_q <= slots_d;
    end

    assign rslot = slots_q[raddr];
endmodule

// File: rtl/adc_seq_result_bank.sv
module adc_seq_result_bank #(
    parameter int N_SLOTS = 16,
    parameter int DATA_W  = 12,
    localparam int ADDR_W = $clog2(N_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [N_SLOTS-1:0] ie_mask,
    input  logic              ovf_clr,
    output logic [N_SLOTS-1:0] flags,
    output logic              ovf,
    output logic              irq
);
    typedef struct packed {
        logic [N_SLOTS-1:0][DATA_W-1:0] mem;
        logic [N_SLOTS-1:0]             flg;
        logic                           ovf;
    } res_regs_t;

    res_regs_t d, q;
    logic      read_same;

    always_comb begin
        d         = q;
        read_same = rd_en && (rd_addr == wr_addr);
        if (ovf_clr) d.ovf = 1'b0;
        if (rd_en)   d.flg[rd_addr] = 1'b0;
        if (wr_en) begin
            d.mem[wr_addr] = wr_data;
            d.flg[wr_addr] = 1'b1;
            if (q.flg[wr_addr] && !read_same) d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_data = q.mem[rd_addr];
    assign flags   = q.flg;
    assign ovf     = q.ovf;
    assign irq     = |(q.flg & ie_mask);

    assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> flags[$past(wr_addr)]);

    assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !(wr_en && wr_addr == rd_addr)) |=> !flags[$past(rd_addr)]);

    assert_overflow_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && flags[wr_addr] && !(rd_en && rd_addr == wr_addr)) |=> ovf);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int N_SLOTS = 16,
    parameter int DATA_W  = 12,
    localparam int ADDR_W = $clog2(N_SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [1:0]         mode,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic               multi,
    input  logic               trig_sw_sel,
    input  logic               sw_start,
    input  logic               hw_trig,
    input  logic               slot_we,
    input  logic [ADDR_W-1:0]  slot_waddr,
    input  logic [CHAN_W-1:0]  slot_wchan,
    input  logic [REF_W-1:0]   slot_wref,
    input  logic               slot_weos,
    output logic               conv_start,
    output logic [CHAN_W-1:0]  conv_chan,
    output logic [REF_W-1:0]   conv_ref,
    input  logic               conv_done,
    input  logic [DATA_W-1:0]  conv_data,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [N_SLOTS-1:0] ie_mask,
    input  logic               ovf_clr,
    output logic [N_SLOTS-1:0] flags,
    output logic               ovf,
    output logic               irq,
    output logic               busy
);
    localparam logic [ADDR_W-1:0] LAST_SLOT = ADDR_W'(N_SLOTS - 1);

    typedef struct packed {
        seq_state_e        state;
        seq_mode_e         run_mode;
        logic [ADDR_W-1:0] ptr;
        logic              start;
        logic              rearm;
        logic              trig;
    } seq_regs_t;

    seq_regs_t d, q;
    slot_t     cur_slot;
    slot_t     wr_slot;
    logic      trig_evt, accept_new, abort_now, store_res, last_slot;
    logic [ADDR_W-1:0] ptr_next;

    assign wr_slot = '{chan: slot_wchan, refsel: slot_wref, eos: slot_weos};

    adc_seq_slot_bank #(.N_SLOTS(N_SLOTS)) slot_bank_i (
        .clk(clk), .rst_n(rst_n), .we(slot_we), .waddr(slot_waddr),
        .wslot(wr_slot), .raddr(q.ptr), .rslot(cur_slot)
    );

    always_comb begin
        d          = q;
        d.start    = 1'b0;
        d.trig     = hw_trig;
        trig_evt   = trig_sw_sel ? sw_start : (hw_trig && !q.trig);
        accept_new = enable && trig_evt && (trig_sw_sel || !q.rearm);
        abort_now  = !enable && (seq_mode_e'(mode) == MODE_SINGLE ||
                                 (q.state != ST_IDLE && q.run_mode == MODE_SINGLE));
        store_res  = (q.state == ST_CONV) && conv_done && !abort_now;
        last_slot  = cur_slot.eos;
        ptr_next   = (q.ptr == LAST_SLOT) ? '0 : q.ptr + 1'b1;

        if (!enable) d.rearm = 1'b0;

        unique case (q.state)
            ST_IDLE: begin
                if (accept_new) begin
                    d.run_mode = seq_mode_e'(mode);
                    d.ptr      = start_addr;
                    d.state    = ST_CONV;
                    d.start    = 1'b1;
                end
            end
            ST_WAIT: begin
                if (!enable) begin
                    if (q.run_mode == MODE_REP_SINGLE) d.state = ST_IDLE;
                    else begin
                        d.state = ST_CONV;
                        d.start = 1'b1;
                    end
                end else if (trig_evt) begin
                    d.state = ST_CONV;
                    d.start = 1'b1;
                end
            end
            ST_CONV: begin
                if (conv_done) begin
                    if (q.run_mode == MODE_SINGLE ||
                        (q.run_mode != MODE_REP_SINGLE && last_slot) ||
                        (q.run_mode == MODE_REP_SINGLE && !enable)) begin
                        d.state = ST_IDLE;
                        if (q.run_mode == MODE_SINGLE || q.run_mode == MODE_SEQ)
                            d.rearm = enable && !trig_sw_sel;
                    end else begin
                        if (q.run_mode != MODE_REP_SINGLE) d.ptr = ptr_next;
                        if (multi || !enable) d.start = 1'b1;
                        else                  d.state = ST_WAIT;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase

        if (abort_now) begin
            d.state = ST_IDLE;
            d.start = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: ST_IDLE, run_mode: MODE_SINGLE, default: '0};
        else        q <= d;
    end

    adc_seq_result_bank #(.N_SLOTS(N_SLOTS), .DATA_W(DATA_W)) result_bank_i (
        .clk(clk), .rst_n(rst_n), .wr_en(store_res), .wr_addr(q.ptr),
        .wr_data(conv_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .ie_mask(ie_mask), .ovf_clr(ovf_clr), .flags(flags), .ovf(ovf), .irq(irq)
    );

    assign conv_start = q.start;
    assign conv_chan  = cur_slot.chan;
    assign conv_ref   = cur_slot.refsel;
    assign busy       = (q.state != ST_IDLE);

    assert_start_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && !conv_done) |=> !conv_start);

    assert_abort_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && mode == 2'd0) |=> !busy);

    assert_rearm_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rearm && enable && !trig_sw_sel) |=> !conv_start);

    assert_idle_no_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !enable) |=> !conv_start);
endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb_top;
    localparam int LAT = 3;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        enable = 0, multi = 0, trig_sw_sel = 1, sw_start = 0, hw_trig = 0;
    logic [1:0]  mode = 0;
    logic [3:0]  start_addr = 0;
    logic        slot_we = 0, slot_weos = 0;
    logic [3:0]  slot_waddr = 0, slot_wchan = 0;
    logic [2:0]  slot_wref = 0;
    logic        conv_start, conv_done = 0;
    logic [3:0]  conv_chan;
    logic [2:0]  conv_ref;
    logic [11:0] conv_data = 0;
    logic        rd_en = 0;
    logic [3:0]  rd_addr = 0;
    logic [11:0] rd_data;
    logic [15:0] ie_mask = 0, flags;
    logic        ovf_clr = 0, ovf, irq, busy;

    int n_chk = 0, n_bad = 0;
    int log_n = 0, cnt = 0;
    logic [3:0] log_chan [0:63];
    logic [2:0] log_ref  [0:63];

    always #4 clk = ~clk;

    adc_seq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .start_addr(start_addr),
        .multi(multi), .trig_sw_sel(trig_sw_sel), .sw_start(sw_start), .hw_trig(hw_trig),
        .slot_we(slot_we), .slot_waddr(slot_waddr), .slot_wchan(slot_wchan),
        .slot_wref(slot_wref), .slot_weos(slot_weos), .conv_start(conv_start),
        .conv_chan(conv_chan), .conv_ref(conv_ref), .conv_done(conv_done),
        .conv_data(conv_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .ie_mask(ie_mask), .ovf_clr(ovf_clr), .flags(flags), .ovf(ovf), .irq(irq),
        .busy(busy)
    );

    // converter model: answers each start LAT cycles later, result = {chan, index}
    initial begin : conv_model
        forever begin
            @(negedge clk);
            if (conv_done) conv_done = 1'b0;
            if (conv_start) begin
                log_chan[log_n % 64] = conv_chan;
                log_ref[log_n % 64]  = conv_ref;
                conv_data = {conv_chan, 8'(log_n)};
                log_n++;
                cnt = LAT;
            end else if (cnt > 0) begin
                cnt--;
                if (cnt == 0) conv_done = 1'b1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_quiet();
        int guard = 0;
        do begin
            @(negedge clk); #1;
            guard++;
        end while (!(cnt == 0 && !conv_done && !conv_start) && guard < 500);
        settle(2);
    endtask

    task automatic sw_pulse();
        @(negedge clk) sw_start = 1'b1;
        @(negedge clk) sw_start = 1'b0;
    endtask

    task automatic hw_pulse();
        @(negedge clk) hw_trig = 1'b1;
        settle(2);
        hw_trig = 1'b0;
    endtask

    task automatic set_slot(input int a, input int ch, input int rf, input bit e);
        @(negedge clk);
        slot_we = 1; slot_waddr = 4'(a); slot_wchan = 4'(ch); slot_wref = 3'(rf); slot_weos = e;
        @(negedge clk) slot_we = 0;
    endtask

    task automatic read_slot(input int a, output logic [11:0] v);
        @(negedge clk);
        rd_en = 1; rd_addr = 4'(a);
        #1 v = rd_data;
        @(negedge clk) rd_en = 0;
    endtask

    task automatic clear_all();
        logic [11:0] v;
        for (int i = 0; i < 16; i++) read_slot(i, v);
        @(negedge clk) ovf_clr = 1;
        @(negedge clk) ovf_clr = 0;
        log_n = 0;
    endtask

    task automatic t_reset();
        chk("R13 busy after reset", busy, 0);
        chk("R13 start after reset", conv_start, 0);
        chk("R13 flags after reset", flags, 0);
        chk("R13 ovf/irq after reset", {ovf, irq}, 0);
    endtask

    task automatic t_single();
        logic [11:0] v;
        mode = 0; start_addr = 5; trig_sw_sel = 1; enable = 1; multi = 0;
        sw_pulse(); wait_quiet();
        chk("R1 one conversion", log_n, 1);
        chk("R13 channel of slot 5", log_chan[0], 10);
        chk("R13 reference of slot 5", log_ref[0], 5);
        chk("R1 only slot 5 flagged", flags, 16'h0020);
        chk("R1 idle after run", busy, 0);
        read_slot(5, v);
        chk("R9 read data channel", v[11:8], 10);
        settle(1);
        chk("R9 read clears flag", flags, 0);
        clear_all();
    endtask

    task automatic t_seq_multi();
        mode = 1; start_addr = 14; multi = 1; enable = 1;
        sw_pulse(); settle(3); sw_pulse(); wait_quiet();
        chk("R2 R4 count with wrap", log_n, 4);
        chk("R2 order", {log_chan[0], log_chan[1], log_chan[2], log_chan[3]}, 16'h10FE);
        chk("R2 flags 14,15,0,1", flags, 16'hC003);
        chk("R4 extra trigger ignored, idle", busy, 0);
        clear_all();
    endtask

    task automatic t_seq_step();
        mode = 1; start_addr = 0; multi = 0; enable = 1;
        sw_pulse(); wait_quiet();
        chk("R3 one conversion per trigger", log_n, 1);
        chk("R3 still busy between triggers", busy, 1);
        sw_pulse(); wait_quiet();
        chk("R3 second trigger ends at eos", log_n, 2);
        chk("R3 idle after eos", busy, 0);
        chk("R3 flags", flags, 16'h0003);
        clear_all();
    endtask

    task automatic t_flags();
        logic [11:0] v;
        mode = 0; start_addr = 5; multi = 0; enable = 1; ie_mask = 16'h0020;
        sw_pulse(); wait_quiet();
        chk("R11 irq with enabled flag", irq, 1);
        ie_mask = 16'h0010; #1;
        chk("R11 irq masked", irq, 0);
        chk("R10 no overflow yet", ovf, 0);
        sw_pulse(); wait_quiet();
        chk("R10 overflow on unread slot", ovf, 1);
        @(negedge clk) ovf_clr = 1;
        @(negedge clk) ovf_clr = 0;
        chk("R10 ovf cleared", ovf, 0);
        read_slot(5, v);
        sw_pulse(); wait_quiet();
        chk("R10 no overflow after read", ovf, 0);
        ie_mask = 0;
        clear_all();
    endtask

    task automatic t_rearm();
        mode = 0; start_addr = 3; trig_sw_sel = 0; enable = 1;
        hw_pulse(); wait_quiet();
        chk("R8 first hw trigger", log_n, 1);
        hw_pulse(); wait_quiet();
        chk("R8 second hw edge blocked", log_n, 1);
        @(negedge clk) enable = 0;
        @(negedge clk) enable = 1;
        hw_pulse(); wait_quiet();
        chk("R8 accepted after enable toggle", log_n, 2);
        trig_sw_sel = 1;
        sw_pulse(); wait_quiet();
        sw_pulse(); wait_quiet();
        chk("R8 repeated software starts", log_n, 4);
        clear_all();
    endtask

    task automatic t_rep_single();
        int n1;
        bit same = 1;
        mode = 2; start_addr = 7; multi = 1; enable = 1;
        sw_pulse(); settle(30); sw_pulse(); settle(5);
        @(negedge clk) enable = 0;
        wait_quiet();
        n1 = log_n;
        chk("R4 continuous conversions", n1 >= 5, 1);
        for (int i = 0; i < n1 && i < 64; i++) if (log_chan[i] != 8) same = 0;
        chk("R5 same slot every time", same, 1);
        chk("R5 stopped after enable clear", busy, 0);
        chk("R5 last conversion stored", flags[7], 1);
        settle(20);
        chk("R5 no further conversion", log_n, n1);
        clear_all();
    endtask

    task automatic t_rep_seq();
        mode = 3; start_addr = 14; multi = 1; enable = 1;
        sw_pulse(); wait_quiet();
        chk("R6 one sequence then idle", log_n, 4);
        chk("R6 idle between sequences", busy, 0);
        sw_pulse(); wait_quiet();
        chk("R6 restart count", log_n, 8);
        chk("R6 restart at start slot", log_chan[4], 1);
        clear_all();
    endtask

    task automatic t_stop_seq();
        mode = 1; start_addr = 14; multi = 0; enable = 1;
        sw_pulse(); wait_quiet();
        chk("R7 one conversion before stop", log_n, 1);
        @(negedge clk) enable = 0;
        wait_quiet();
        chk("R7 sequence completed", log_n, 4);
        chk("R7 idle", busy, 0);
        chk("R7 flags of full sequence", flags, 16'hC003);
        clear_all();
    endtask

    task automatic t_abort();
        mode = 0; start_addr = 2; multi = 0; enable = 1;
        sw_pulse(); settle(1);
        @(negedge clk) enable = 0;
        @(negedge clk); #1;
        chk("R12 idle at next edge", busy, 0);
        settle(10);
        chk("R12 no result stored", flags, 0);
        clear_all();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        settle(3);
        rst_n = 1;
        settle(1);
        for (int k = 0; k < 16; k++) set_slot(k, 15 - k, k % 8, k == 1);
        t_reset();
        t_single();
        t_seq_multi();
        t_seq_step();
        t_flags();
        t_rearm();
        t_rep_single();
        t_rep_seq();
        t_stop_seq();
        t_abort();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule